// File: doc/BRIEF.md
# Keyboard Scan Matrix Emulator

This block turns a stream of 8-bit character codes into the contents of a simulated key-scan matrix. A host sees six 16-bit scan words and one interrupt status register through a small register interface. It also sees a level interrupt that stays high while any status bit is set. Each character sets one key bit in one scan word. Shifted letters and control codes are handled in two steps: the first step sets a modifier bit and holds the matrix for one scan; the second step feeds the base character back in, so that key and modifier are reported together.

The block works in scan periods marked by a one-cycle `scan_tick` pulse. On each tick the matrix is cleared, unless it is being held, and at most one character is taken in. A character fed back internally always wins over new input. A three-state escape parser turns cursor-key sequences (ESC, `[`, final letter) into arrow-key bits.

The parser states are ESC_IDLE, ESC_WANT_BRKT and ESC_WANT_FINAL. Their transitions are:

| From | Condition | To |
|------|-----------|----|
| ESC_IDLE | code 27 | ESC_WANT_BRKT |
| ESC_IDLE | any other code | ESC_IDLE |
| ESC_WANT_BRKT | `[` | ESC_WANT_FINAL |
| ESC_WANT_BRKT | any other code | ESC_IDLE |
| ESC_WANT_FINAL | any code | ESC_IDLE |

The parser only changes state on a tick that takes in a character.

Top module: `kbd_scan_emu`

## Requirements
- R1: After reset, all six scan words read 0x0000, the status reads 0, `irq` is low and the parser is in ESC_IDLE.
- R2: Scan word i reads at byte address 2*i (0x00, 0x02, 0x04, 0x06, 0x08, 0x0A). Status reads at 0x10. Every other address reads 0. Writes to scan words have no effect.
- R3: On a tick with the hold flag clear, all scan words are cleared. On a tick with the hold flag set, the words are kept and the flag is cleared. Between ticks the words do not change.
- R4: At most one character is taken per tick. `char_ready` is high only during a tick with no fed-back character pending. A pending fed-back character is taken on the next tick, before any new input.
- R5: In ESC_IDLE a mapped character replaces the value of its scan word with its key bit. Examples: space is word 0 0x0001; CR (13) or LF (10) is word 0 0x0040; backspace (8) is word 4 0x0010; 'a' is word 1 0x8000; 'z' is word 1 0x0080; 'c' is word 1 0x0020; '1' is word 3 0x0080.
- R6: In ESC_IDLE an uppercase letter (65..90) sets word 5 to 0x0800 (shift), sets the hold flag and feeds back the code plus 32.
- R7: In ESC_IDLE a control code from 1 to 26, other than 8, 10 and 13, sets word 5 to 0x0004 (ctrl), sets the hold flag and feeds back the code plus 96.
- R8: Escape parsing follows the state table. In ESC_WANT_FINAL, 'A', 'B', 'C' and 'D' set word 0 to 0x1000, 0x2000, 0x0020 and 0x0010.
- R9: Unmapped characters and unknown final codes leave the scan words as the tick's clear left them.
- R10: A tick ORs 0x3 (key detected, data complete) into status when any scan word was nonzero before the tick, or when a character was taken and the parser is in ESC_IDLE afterwards. Status bit 2 (lost data) always reads 0.
- R11: Writing the status address clears the status bits written as one. A set from the same tick wins over the clear.
- R12: `irq` is high exactly when the status is nonzero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| scan_tick | input | 1 | One-cycle pulse that starts a scan period |
| char_valid | input | 1 | Character offered |
| char_data | input | 8 | Offered character code |
| char_ready | output | 1 | Character taken this cycle when valid |
| reg_addr | input | 5 | Byte address of register access |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 16 | Write data |
| reg_rdata | output | 16 | Read data for reg_addr (combinational) |
| irq | output | 1 | Interrupt, high while status is nonzero |

## Verification
The checker assumes that `scan_tick` is a pulse and that the inputs hold still around the clock edge. It also assumes that a status clear can only come from a write strobe to address 0x10. The bench changes inputs just after the falling edge and drops every strobe after one cycle. It offers a character only together with a tick. When a fed-back character is pending it either waits for that character to drain, or offers a character on purpose to show that the offer is refused.

// File: rtl/kbd_pkg.sv
package kbd_pkg;
    localparam int KEY_W      = 16;
    localparam int KEY_WORDS  = 6;
    localparam int KIDX_W     = 3;
    localparam logic [KIDX_W-1:0] MOD_WORD  = 3'd5;
    localparam logic [KEY_W-1:0]  SHIFT_BIT = 16'h0800;
    localparam logic [KEY_W-1:0]  CTRL_BIT  = 16'h0004;
    localparam logic [7:0] CODE_ESC = 8'd27;

    typedef enum logic [1:0] {
        ESC_IDLE       = 2'd0,
        ESC_WANT_BRKT  = 2'd1,
        ESC_WANT_FINAL = 2'd2
    } esc_state_t;

    typedef struct packed {
        logic              hit;
        logic [KIDX_W-1:0] idx;
        logic [KEY_W-1:0]  bits;
    } keymap_t;

    function automatic keymap_t km(input int w, input logic [KEY_W-1:0] b);
        keymap_t r;
        r.hit  = 1'b1;
        r.idx  = KIDX_W'(w);
        r.bits = b;
        return r;
    endfunction

    function automatic keymap_t lookup_key(input logic [7:0] ch);
        keymap_t r;
        r = '0;
        case (ch)
            8'h20: r = km(0, 16'h0001);  8'h5D: r = km(0, 16'h0002);
            8'h5C: r = km(0, 16'h0004);  8'h2F: r = km(0, 16'h0008);
            8'h0D: r = km(0, 16'h0040);  8'h0A: r = km(0, 16'h0040);
            8'h6C: r = km(0, 16'h0080);  8'h5B: r = km(0, 16'h0200);
            8'h27: r = km(0, 16'h0400);  8'h3B: r = km(0, 16'h0800);
            8'h2E: r = km(0, 16'h4000);  8'h6F: r = km(0, 16'h8000);
            8'h76: r = km(1, 16'h0010);  8'h63: r = km(1, 16'h0020);
            8'h78: r = km(1, 16'h0040);  8'h7A: r = km(1, 16'h0080);
            8'h3D: r = km(1, 16'h0200);  8'h2D: r = km(1, 16'h0400);
            8'h66: r = km(1, 16'h1000);  8'h64: r = km(1, 16'h2000);
            8'h73: r = km(1, 16'h4000);  8'h61: r = km(1, 16'h8000);
            8'h38: r = km(2, 16'h0001);  8'h37: r = km(2, 16'h0002);
            8'h36: r = km(2, 16'h0004);  8'h35: r = km(2, 16'h0008);
            8'h72: r = km(2, 16'h0010);  8'h65: r = km(2, 16'h0020);
            8'h77: r = km(2, 16'h0040);  8'h71: r = km(2, 16'h0080);
            8'h2C: r = km(2, 16'h0100);  8'h6D: r = km(2, 16'h0200);
            8'h6E: r = km(2, 16'h0400);  8'h62: r = km(2, 16'h0800);
            8'h30: r = km(2, 16'h4000);  8'h39: r = km(2, 16'h8000);
            8'h6B: r = km(3, 16'h0001);  8'h6A: r = km(3, 16'h0002);
            8'h68: r = km(3, 16'h0004);  8'h67: r = km(3, 16'h0008);
            8'h34: r = km(3, 16'h0010);  8'h33: r = km(3, 16'h0020);
            8'h32: r = km(3, 16'h0040);  8'h31: r = km(3, 16'h0080);
            8'h69: r = km(3, 16'h0100);  8'h75: r = km(3, 16'h0200);
            8'h79: r = km(3, 16'h0400);  8'h74: r = km(3, 16'h0800);
            8'h08: r = km(4, 16'h0010);  8'h70: r = km(4, 16'h0020);
            default: r = '0;
        endcase
        return r;
    endfunction
endpackage

// File: rtl/kbd_char_src.sv
module kbd_char_src (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       tick,
    input  logic       in_valid,
    input  logic [7:0] in_data,
    output logic       in_ready,
    input  logic       push_en,
    input  logic [7:0] push_ch,
    output logic       take,
    output logic [7:0] cur_ch
);
    logic       pb_valid;
    logic [7:0] pb_ch;

    assign in_ready = tick && !pb_valid;
    assign take     = tick && (pb_valid || in_valid);
    assign cur_ch   = pb_valid ? pb_ch : in_data;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pb_valid <= 1'b0;
            pb_ch    <= '0;
        end else if (push_en) begin
            pb_valid <= 1'b1;
            pb_ch    <= push_ch;
        end else if (take && pb_valid) begin
            pb_valid <= 1'b0;
        end
    end
endmodule

// File: rtl/kbd_esc_fsm.sv
module kbd_esc_fsm
    import kbd_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              take,
    input  logic [7:0]        ch,
    output logic              wr_en,
    output logic [KIDX_W-1:0] wr_idx,
    output logic [KEY_W-1:0]  wr_bits,
    output logic              set_hold,
    output logic              push_en,
    output logic [7:0]        push_ch,
    output logic              key_event
);
    esc_state_t state, nxt;
    keymap_t    hit;
    logic       is_upper, is_ctrl;

    always_ff @(posedge clk) begin
        if (!rst_n)
            state <= ESC_IDLE;
        else if (take)
            state <= nxt;
    end

    always_comb begin
        hit      = lookup_key(ch);
        is_upper = (ch >= 8'd65) && (ch <= 8'd90);
        is_ctrl  = (ch >= 8'd1) && (ch <= 8'd26);
        nxt      = state;
        wr_en    = 1'b0;
        wr_idx   = '0;
        wr_bits  = '0;
        set_hold = 1'b0;
        push_en  = 1'b0;
        push_ch  = ch;
        unique case (state)
            ESC_IDLE: begin
                if (ch == CODE_ESC) begin
                    nxt = ESC_WANT_BRKT;
                end else if (hit.hit) begin
                    wr_en   = 1'b1;
                    wr_idx  = hit.idx;
                    wr_bits = hit.bits;
                end else if (is_upper) begin
                    wr_en    = 1'b1;
                    wr_idx   = MOD_WORD;
                    wr_bits  = SHIFT_BIT;
                    set_hold = 1'b1;
                    push_en  = 1'b1;
                    push_ch  = ch + 8'd32;
                end else if (is_ctrl) begin
                    wr_en    = 1'b1;
                    wr_idx   = MOD_WORD;
                    wr_bits  = CTRL_BIT;
                    set_hold = 1'b1;
                    push_en  = 1'b1;
                    push_ch  = ch + 8'd96;
                end
            end
            ESC_WANT_BRKT: begin
                nxt = (ch == 8'h5B) ? ESC_WANT_FINAL : ESC_IDLE;
            end
            ESC_WANT_FINAL: begin
                nxt    = ESC_IDLE;
                wr_idx = '0;
                case (ch)
                    8'h41: begin wr_en = 1'b1; wr_bits = 16'h1000; end
                    8'h42: begin wr_en = 1'b1; wr_bits = 16'h2000; end
                    8'h43: begin wr_en = 1'b1; wr_bits = 16'h0020; end
                    8'h44: begin wr_en = 1'b1; wr_bits = 16'h0010; end
                    default: wr_en = 1'b0;
                endcase
            end
            default: nxt = ESC_IDLE;
        endcase
        if (!take) begin
            wr_en    = 1'b0;
            set_hold = 1'b0;
            push_en  = 1'b0;
        end
        key_event = take && (nxt == ESC_IDLE);
    end
endmodule

// File: rtl/kbd_matrix.sv
module kbd_matrix #(
    parameter int N_WORDS = kbd_pkg::KEY_WORDS,
    parameter int WORD_W  = kbd_pkg::KEY_W,
    parameter int IDX_W   = kbd_pkg::KIDX_W,
    parameter int STAT_W  = 3
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      tick,
    input  logic                      wr_en,
    input  logic [IDX_W-1:0]          wr_idx,
    input  logic [WORD_W-1:0]         wr_bits,
    input  logic                      set_hold,
    input  logic                      key_event,
    input  logic [STAT_W-1:0]         stat_clr,
    output logic [N_WORDS*WORD_W-1:0] words_flat,
    output logic [STAT_W-1:0]         status
);
    localparam logic [STAT_W-1:0] KEY_SET = STAT_W'(3);

    logic hold;
    logic any_nz;
    logic keychg;

    assign any_nz = |words_flat;
    assign keychg = tick && (any_nz || key_event);

    for (genvar i = 0; i < N_WORDS; i++) begin : g_word
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words_flat[i*WORD_W +: WORD_W] <= '0;
            end else if (tick) begin
                if (wr_en && (wr_idx == IDX_W'(i)))
                    words_flat[i*WORD_W +: WORD_W] <= wr_bits;
                else if (!hold)
                    words_flat[i*WORD_W +: WORD_W] <= '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hold   <= 1'b0;
            status <= '0;
        end else begin
            if (tick)
                hold <= set_hold;
            status <= (status & ~stat_clr) | (keychg ? KEY_SET : '0);
        end
    end
endmodule

// File: rtl/kbd_scan_emu.sv
module kbd_scan_emu #(
    parameter int N_WORDS = kbd_pkg::KEY_WORDS,
    parameter int WORD_W  = kbd_pkg::KEY_W,
    parameter int ADDR_W  = 5,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              scan_tick,
    input  logic              char_valid,
    input  logic [7:0]        char_data,
    output logic              char_ready,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [WORD_W-1:0] reg_wdata,
    output logic [WORD_W-1:0] reg_rdata,
    output logic              irq
);
    localparam int STAT_W = 3;
    localparam int IDX_W  = kbd_pkg::KIDX_W;

    logic                      take, push_en, wr_en, set_hold, key_event;
    logic [7:0]                cur_ch, push_ch;
    logic [IDX_W-1:0]          wr_idx;
    logic [WORD_W-1:0]         wr_bits;
    logic [STAT_W-1:0]         status, stat_clr;
    logic [N_WORDS*WORD_W-1:0] words_flat;

    kbd_char_src u_src (
        .clk(clk), .rst_n(rst_n), .tick(scan_tick),
        .in_valid(char_valid), .in_data(char_data), .in_ready(char_ready),
        .push_en(push_en), .push_ch(push_ch), .take(take), .cur_ch(cur_ch)
    );

    kbd_esc_fsm u_fsm (
        .clk(clk), .rst_n(rst_n), .take(take), .ch(cur_ch),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bits(wr_bits),
        .set_hold(set_hold), .push_en(push_en), .push_ch(push_ch),
        .key_event(key_event)
    );

    kbd_matrix #(.N_WORDS(N_WORDS), .WORD_W(WORD_W), .IDX_W(IDX_W), .STAT_W(STAT_W)) u_mat (
        .clk(clk), .rst_n(rst_n), .tick(scan_tick),
        .wr_en(wr_en), .wr_idx(wr_idx), .wr_bits(wr_bits),
        .set_hold(set_hold), .key_event(key_event), .stat_clr(stat_clr),
        .words_flat(words_flat), .status(status)
    );

    assign stat_clr = (reg_wr && (reg_addr == STAT_ADDR)) ? reg_wdata[STAT_W-1:0] : '0;
    assign irq      = |status;

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < N_WORDS; i++) begin
            if (reg_addr == ADDR_W'(2 * i))
                reg_rdata = words_flat[i*WORD_W +: WORD_W];
        end
        if (reg_addr == STAT_ADDR)
            reg_rdata = {{(WORD_W-STAT_W){1'b0}}, status};
    end
endmodule

// File: rtl/kbd_scan_emu_chk.sv
module kbd_scan_emu_chk #(
    parameter int ADDR_W = 5,
    parameter int WORD_W = 16,
    parameter int FLAT_W = 96,
    parameter logic [ADDR_W-1:0] STAT_ADDR = 5'h10
) (
    input logic              clk,
    input logic              rst_n,
    input logic              scan_tick,
    input logic              char_valid,
    input logic [7:0]        char_data,
    input logic              char_ready,
    input logic [ADDR_W-1:0] reg_addr,
    input logic              reg_wr,
    input logic [WORD_W-1:0] reg_rdata,
    input logic              irq,
    input logic [FLAT_W-1:0] words_flat
);
    AST_READY_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        char_ready |-> scan_tick); // R4

    AST_WORDS_STILL_OFF_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        !scan_tick |=> $stable(words_flat)); // R3

    AST_SPACE_RAISES_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        (scan_tick && char_valid && char_ready && char_data == 8'h20) |=> irq); // R10

    AST_IRQ_DROP_NEEDS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(irq) |-> $past(reg_wr && reg_addr == STAT_ADDR)); // R11

    AST_LOST_BIT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (reg_addr == STAT_ADDR) |-> (reg_rdata[2] == 1'b0)); // R10
endmodule

bind kbd_scan_emu kbd_scan_emu_chk #(
    .ADDR_W(ADDR_W), .WORD_W(WORD_W), .FLAT_W(N_WORDS*WORD_W), .STAT_ADDR(STAT_ADDR)
) u_chk (
    .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .char_valid(char_valid),
    .char_data(char_data), .char_ready(char_ready), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_rdata(reg_rdata), .irq(irq), .words_flat(words_flat)
);

// File: tb/tb_kbd_scan_emu.sv
`timescale 1ns/1ps
module tb_kbd_scan_emu;
    localparam logic [4:0] STAT = 5'h10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        scan_tick = 1'b0, char_valid = 1'b0, reg_wr = 1'b0;
    logic [7:0]  char_data = '0;
    logic [4:0]  reg_addr = '0;
    logic [15:0] reg_wdata = '0;
    logic        char_ready, irq;
    logic [15:0] reg_rdata;

    int n_chk = 0, n_fail = 0;
    bit finished = 0;

    // behavioural reference
    int m_words[6];
    int m_status, m_esc, m_hold;
    int pbq[$];
    int lut_w[int];
    int lut_b[int];

    always #5 clk = ~clk;

    kbd_scan_emu dut (
        .clk(clk), .rst_n(rst_n), .scan_tick(scan_tick), .char_valid(char_valid),
        .char_data(char_data), .char_ready(char_ready), .reg_addr(reg_addr),
        .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq)
    );

    task automatic chk(string tag, int act, int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
        end
    endtask

    task automatic put(int c, int w, int b);
        lut_w[c] = w;
        lut_b[c] = b;
    endtask

    function automatic int model_read(int a);
        if (a == STAT) return m_status;
        if (a % 2 == 0 && a / 2 < 6) return m_words[a / 2];
        return 0;
    endfunction

    function automatic bit model_char(int c);
        if (m_esc == 0) begin
            if (c == 27) m_esc = 1;
            else if (lut_w.exists(c)) m_words[lut_w[c]] = lut_b[c];
            else if (c >= 65 && c <= 90) begin m_words[5] = 'h800; m_hold = 1; pbq.push_back(c + 32); end
            else if (c >= 1 && c <= 26) begin m_words[5] = 'h4; m_hold = 1; pbq.push_back(c + 96); end
        end else if (m_esc == 1) begin
            m_esc = (c == 91) ? 2 : 0;
        end else begin
            if (c == 65) m_words[0] = 'h1000;
            if (c == 66) m_words[0] = 'h2000;
            if (c == 67) m_words[0] = 'h20;
            if (c == 68) m_words[0] = 'h10;
            m_esc = 0;
        end
        return m_esc == 0;
    endfunction

    always @(posedge clk) begin
        if (!rst_n) begin
            foreach (m_words[i]) m_words[i] = 0;
            m_status = 0; m_esc = 0; m_hold = 0;
            pbq.delete();
        end else begin
            int clr, set;
            clr = (reg_wr && reg_addr == STAT) ? (reg_wdata & 7) : 0;
            set = 0;
            if (scan_tick) begin
                bit nz, have;
                int c;
                nz = 0;
                foreach (m_words[i]) if (m_words[i] != 0) nz = 1;
                if (m_hold != 0) m_hold = 0;
                else foreach (m_words[i]) m_words[i] = 0;
                have = 0;
                if (pbq.size() > 0) begin c = pbq.pop_front(); have = 1; end
                else if (char_valid) begin c = char_data; have = 1; end
                if (have && model_char(c)) nz = 1;
                if (nz) set = 3;
            end
            m_status = (m_status & ~clr) | set;
        end
    end

    // every-cycle comparison, away from the rising edge
    always @(negedge clk) begin
        if (rst_n) begin
            chk("R12 irq", irq, m_status != 0);
            chk("R4 char_ready", char_ready, scan_tick && pbq.size() == 0);
            chk("R2 rdata", reg_rdata, model_read(reg_addr));
        end
    end

    task automatic cyc(bit t, bit v, int c, bit w, int wd, int a);
        scan_tick = t; char_valid = v; char_data = 8'(c);
        reg_wr = w; reg_wdata = 16'(wd); reg_addr = 5'(a);
        @(negedge clk); #1;
        scan_tick = 0; char_valid = 0; reg_wr = 0;
    endtask

    task automatic key(int c);
        cyc(1, 1, c, 0, 0, 0);
    endtask

    task automatic rd(int a, int exp, string tag);
        reg_addr = 5'(a);
        @(negedge clk);
        chk(tag, reg_rdata, exp);
        #1;
    endtask

    task automatic clr_stat();
        cyc(0, 0, 0, 1, 'h7, STAT);
    endtask

    initial begin
        put(32, 0, 'h1); put(13, 0, 'h40); put(10, 0, 'h40); put(8, 4, 'h10);
        put(112, 4, 'h20); put(97, 1, 'h8000); put(122, 1, 'h80); put(99, 1, 'h20);
        put(49, 3, 'h80); put(93, 0, 'h2); put(92, 0, 'h4); put(47, 0, 'h8);
        put(108, 0, 'h80); put(91, 0, 'h200); put(39, 0, 'h400); put(59, 0, 'h800);
        put(46, 0, 'h4000); put(111, 0, 'h8000); put(118, 1, 'h10); put(120, 1, 'h40);
        put(61, 1, 'h200); put(45, 1, 'h400); put(102, 1, 'h1000); put(100, 1, 'h2000);
        put(115, 1, 'h4000); put(56, 2, 'h1); put(55, 2, 'h2); put(54, 2, 'h4);
        put(53, 2, 'h8); put(114, 2, 'h10); put(101, 2, 'h20); put(119, 2, 'h40);
        put(113, 2, 'h80); put(44, 2, 'h100); put(109, 2, 'h200); put(110, 2, 'h400);
        put(98, 2, 'h800); put(48, 2, 'h4000); put(57, 2, 'h8000); put(107, 3, 'h1);
        put(106, 3, 'h2); put(104, 3, 'h4); put(103, 3, 'h8); put(52, 3, 'h10);
        put(51, 3, 'h20); put(50, 3, 'h40); put(105, 3, 'h100); put(117, 3, 'h200);
        put(121, 3, 'h400); put(116, 3, 'h800);

        repeat (3) @(negedge clk);
        #1 rst_n = 1;
        for (int i = 0; i < 6; i++) rd(2 * i, 0, "R1 word after reset");
        rd(STAT, 0, "R1 status after reset");
        chk("R1 irq after reset", irq, 0);

        // R2 holes and ignored writes
        rd('h0C, 0, "R2 hole 0x0C");
        rd('h01, 0, "R2 odd address");
        rd('h1E, 0, "R2 hole 0x1E");
        cyc(0, 0, 0, 1, 'hFFFF, 0);
        rd(0, 0, "R2 word write ignored");

        // R5 space, R10 status, R12 irq
        key(32);
        rd(0, 'h1, "R5 space word0");
        rd(STAT, 3, "R10 status after key");
        chk("R12 irq high", irq, 1);
        cyc(0, 0, 0, 1, 'h1, STAT);
        rd(STAT, 2, "R11 clear bit0 only");
        cyc(0, 0, 0, 1, 'h2, STAT);
        rd(STAT, 0, "R11 clear bit1");
        chk("R12 irq low", irq, 0);

        // R3 clear on tick, R10 nonzero-before-clear event
        cyc(1, 0, 0, 0, 0, 0);
        rd(0, 0, "R3 words cleared");
        rd(STAT, 3, "R10 event from nonzero words");
        clr_stat();
        cyc(1, 0, 0, 0, 0, 0);
        rd(STAT, 0, "R10 idle tick no event");

        // R6 shift with hold and pushback; R4 pushback priority
        key(65);
        rd(10, 'h800, "R6 shift bit");
        rd(2, 0, "R6 letter not yet");
        scan_tick = 1; char_valid = 1; char_data = 8'd122; reg_addr = 0;
        #2 chk("R4 ready low while pushback pending", char_ready, 0);
        @(negedge clk); #1; scan_tick = 0; char_valid = 0;
        rd(2, 'h8000, "R6 pushed letter a");
        rd(10, 'h800, "R3 hold kept shift");
        key(122);
        rd(2, 'h80, "R4 new input after pushback");
        rd(10, 0, "R3 shift cleared after hold");

        // R7 ctrl-c, and codes 8/13 are keys not ctrl
        key(3);
        rd(10, 'h4, "R7 ctrl bit");
        cyc(1, 0, 0, 0, 0, 0);
        rd(2, 'h20, "R7 pushed c");
        rd(10, 'h4, "R7 ctrl held");
        key(8);
        rd(8, 'h10, "R5 backspace word4");
        rd(10, 0, "R7 code 8 not ctrl");
        key(13);
        rd(0, 'h40, "R5 CR word0");
        key(49);
        rd(6, 'h80, "R5 digit 1 word3");

        // R8 escape sequences, R10 no event mid-sequence
        cyc(1, 0, 0, 0, 0, 0);
        clr_stat();
        key(27);
        rd(STAT, 0, "R10 no event on ESC");
        key(91);
        rd(STAT, 0, "R10 no event on bracket");
        key(67);
        rd(0, 'h20, "R8 arrow C");
        rd(STAT, 3, "R10 event on final");
        key(27); key(91); key(65);
        rd(0, 'h1000, "R8 arrow A");
        key(27); key(91); key(68);
        rd(0, 'h10, "R8 arrow D");
        key(27); key(91); key(66);
        rd(0, 'h2000, "R8 arrow B");

        // R9 unknown final, then parser back to idle
        key(27); key(91); key(90);
        for (int i = 0; i < 6; i++) rd(2 * i, 0, "R9 unknown final no bits");
        key(65);
        rd(10, 'h800, "R8 idle after unknown final");
        rd(0, 0, "R8 A not taken as arrow");
        cyc(1, 0, 0, 0, 0, 0);
        key(27); key(120); key(65);
        rd(10, 'h800, "R8 non-bracket returns idle");
        cyc(1, 0, 0, 0, 0, 0);

        // R9 unmapped character
        cyc(1, 0, 0, 0, 0, 0);
        clr_stat();
        key(126);
        for (int i = 0; i < 6; i++) rd(2 * i, 0, "R9 unmapped no bits");
        rd(STAT, 3, "R10 unmapped still consumed");

        // R11 set wins over same-cycle clear
        clr_stat();
        cyc(1, 1, 32, 1, 'h7, STAT);
        rd(STAT, 3, "R11 set beats clear");

        finished = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        #1_000_000;
        if (!finished) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end
endmodule